// File: doc/BRIEF.md
# Multiway Branch Resolver with Condition-Flag File

This block resolves every conditional branch that a wide instruction carries, all in one cycle, and produces the program counter of the following instruction. It holds eight single-bit condition flags. Each branch slot in the instruction supplies a slot-valid bit, a target address and two 8-bit selection masks. The "must-be-set" mask names flags that have to read 1. The "must-be-clear" mask names flags that have to read 0. A slot is taken when it is valid and both mask tests pass against the flag values that were stored before the current cycle.

When more than one slot is taken, the slot with the lowest index supplies the next PC, and the block reports that index together with a taken flag. When no slot is taken, the next PC is the current PC plus one. All results are registered, so they appear one cycle after the instruction is presented. The same instruction can also rewrite any subset of the flags. A delay-slot output tells the sequencer that the operation following a branch-bearing instruction must execute whatever the branch outcome.

Top module: `mwb_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all eight flags clear to 0, `next_pc` becomes `RESET_VEC`, `taken` and `delay_slot` become 0, and `win_slot` becomes 0.
- R2: A slot's condition is true exactly when (flags AND must-set mask) equals the must-set mask and (flags AND must-clear mask) equals 0. Bit i of either mask refers to flag i. Slot s uses mask bits [8s+7:8s] and target bits [PC_W*s+PC_W-1:PC_W*s].
- R3: A valid slot whose two masks are both zero is always taken.
- R4: A slot that selects the same flag in both masks is never taken. This case produces no error indication, and the other slots resolve normally.
- R5: The edge that accepts an instruction (`instr_valid` high) sets `taken` to the OR of all taken slots. When `taken` is set, `win_slot` holds the lowest taken index and `next_pc` holds that slot's target.
- R6: Mask tests use the flag values stored before the edge. A flag write presented in the same cycle as an instruction affects only the instructions that follow it.
- R7: When no slot is taken, `next_pc` becomes `cur_pc + 1` modulo 2^PC_W.
- R8: At an edge where `instr_valid` is low, `next_pc`, `taken` and `win_slot` keep their values.
- R9: `delay_slot` goes high for one cycle after an accepted instruction that has at least one valid slot, whether or not a branch is taken. Otherwise it is 0.
- R10: A slot whose valid bit is 0 is never taken, whatever its masks are.
- R11: At each edge, flag i takes `cc_wr_data[i]` when `cc_wr_en[i]` is 1 and otherwise keeps its value. `cc_value` shows the stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| cur_pc | input | PC_W | Address of the presented instruction |
| slot_valid | input | NUM_SLOTS | Per-slot branch present |
| set_masks | input | NUM_SLOTS*8 | Per-slot must-be-set masks |
| clr_masks | input | NUM_SLOTS*8 | Per-slot must-be-clear masks |
| targets | input | NUM_SLOTS*PC_W | Per-slot branch targets |
| cc_wr_en | input | 8 | Per-flag write enable |
| cc_wr_data | input | 8 | Per-flag write value |
| next_pc | output | PC_W | Registered next program counter |
| taken | output | 1 | Registered: some slot was taken |
| win_slot | output | $clog2(NUM_SLOTS) | Registered winning slot index |
| delay_slot | output | 1 | Registered: the following operation must execute |
| cc_value | output | 8 | Stored condition flags |

## Verification
Several properties are checked by assertions on every cycle: overlapping masks never yield a taken slot, slot 0 wins whenever it is taken, fall-through addressing, holding state while idle, delay-slot timing, and the retention of unwritten flags. Only the bench's scenarios can show that the mask arithmetic is correct across all 256 flag states, that a same-cycle flag write stays invisible to the instruction beside it, that targets are routed from the correct slot, and that the PC wraps at the top of its range.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
    localparam int CC_N = 8;

    typedef logic [CC_N-1:0] cc_vec_t;

    typedef struct packed {
        cc_vec_t must_set;
        cc_vec_t must_clr;
    } cond_masks_t;

    typedef enum logic {
        PC_FALL = 1'b0,
        PC_JUMP = 1'b1
    } pc_src_e;

    function automatic logic cond_met(cc_vec_t flags, cond_masks_t m);
        return ((flags & m.must_set) == m.must_set) && ((flags & m.must_clr) == '0);
    endfunction
endpackage

// File: rtl/mwb_cc_file.sv
module mwb_cc_file
    import mwb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cc_vec_t wr_en,
    input  cc_vec_t wr_data,
    output cc_vec_t flags
);
    cc_vec_t flags_q;

    for (genvar g = 0; g < CC_N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[g] <= 1'b0;
            else if (wr_en[g])
                flags_q[g] <= wr_data[g];
        end

        assert_flag_kept_R11: assert property (@(posedge clk) disable iff (rst)
            !wr_en[g] |=> $stable(flags_q[g]));
    end

    assign flags = flags_q;
endmodule

// File: rtl/mwb_slot_eval.sv
module mwb_slot_eval
    import mwb_pkg::*;
(
    input  cc_vec_t     flags,
    input  logic        valid,
    input  cond_masks_t masks,
    output logic        hit
);
    always_comb hit = valid && cond_met(flags, masks);
endmodule

// File: rtl/mwb_prio_pick.sv
module mwb_prio_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/mwb_branch_unit.sv
module mwb_branch_unit
    import mwb_pkg::*;
#(
    parameter int          NUM_SLOTS = 4,
    parameter int          PC_W      = 16,
    parameter logic [15:0] RESET_VEC = 16'h0100,
    localparam int         SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      instr_valid,
    input  logic [PC_W-1:0]           cur_pc,
    input  logic [NUM_SLOTS-1:0]      slot_valid,
    input  logic [NUM_SLOTS*CC_N-1:0] set_masks,
    input  logic [NUM_SLOTS*CC_N-1:0] clr_masks,
    input  logic [NUM_SLOTS*PC_W-1:0] targets,
    input  logic [CC_N-1:0]           cc_wr_en,
    input  logic [CC_N-1:0]           cc_wr_data,
    output logic [PC_W-1:0]           next_pc,
    output logic                      taken,
    output logic [SLOT_W-1:0]         win_slot,
    output logic                      delay_slot,
    output logic [CC_N-1:0]           cc_value
);
    cc_vec_t               flags;
    logic [NUM_SLOTS-1:0]  hit;
    logic                  any_hit;
    logic [SLOT_W-1:0]     pick;
    pc_src_e               src;
    logic [PC_W-1:0]       pc_d;

    logic [PC_W-1:0]       next_pc_q;
    logic                  taken_q;
    logic [SLOT_W-1:0]     win_q;
    logic                  dly_q;

    mwb_cc_file u_cc (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cc_wr_en),
        .wr_data (cc_wr_data),
        .flags   (flags)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        cond_masks_t m;
        assign m.must_set = set_masks[s*CC_N +: CC_N];
        assign m.must_clr = clr_masks[s*CC_N +: CC_N];

        mwb_slot_eval u_eval (
            .flags (flags),
            .valid (slot_valid[s]),
            .masks (m),
            .hit   (hit[s])
        );

        assert_overlap_never_taken_R4: assert property (@(posedge clk) disable iff (rst)
            ((m.must_set & m.must_clr) != '0) |-> !hit[s]);

        assert_invalid_slot_idle_R10: assert property (@(posedge clk) disable iff (rst)
            !slot_valid[s] |-> !hit[s]);
    end

    mwb_prio_pick #(.N(NUM_SLOTS), .IW(SLOT_W)) u_pick (
        .req (hit),
        .any (any_hit),
        .idx (pick)
    );

    always_comb begin
        src  = any_hit ? PC_JUMP : PC_FALL;
        pc_d = (src == PC_JUMP) ? targets[pick*PC_W +: PC_W] : cur_pc + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_q <= RESET_VEC[PC_W-1:0];
            taken_q   <= 1'b0;
            win_q     <= '0;
            dly_q     <= 1'b0;
        end else begin
            dly_q <= instr_valid && (|slot_valid);
            if (instr_valid) begin
                next_pc_q <= pc_d;
                taken_q   <= any_hit;
                win_q     <= pick;
            end
        end
    end

    assign next_pc    = next_pc_q;
    assign taken      = taken_q;
    assign win_slot   = win_q;
    assign delay_slot = dly_q;
    assign cc_value   = flags;

    assert_slot0_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && hit[0]) |=> (taken && win_slot == '0));

    assert_taken_is_any_R5: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> (taken == $past(|hit)));

    assert_fall_through_R7: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && hit == '0) |=> (next_pc == $past(cur_pc) + PC_W'(1)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> ($stable(next_pc) && $stable(taken) && $stable(win_slot)));

    assert_delay_slot_R9: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && slot_valid != '0) |=> delay_slot);

    assert_no_delay_R9: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && slot_valid != '0) |=> !delay_slot);
endmodule

// File: tb/sim_mwb_branch_unit.sv
`timescale 1ns/1ps
module sim_mwb_branch_unit;
    localparam int NS = 4;
    localparam int PW = 16;
    localparam logic [15:0] RV = 16'h0100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic [PW-1:0] cur_pc = '0;
    logic [NS-1:0] slot_valid = '0;
    logic [NS*8-1:0]  set_masks = '0;
    logic [NS*8-1:0]  clr_masks = '0;
    logic [NS*PW-1:0] targets = '0;
    logic [7:0]    cc_wr_en = '0;
    logic [7:0]    cc_wr_data = '0;
    logic [PW-1:0] next_pc;
    logic          taken;
    logic [1:0]    win_slot;
    logic          delay_slot;
    logic [7:0]    cc_value;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mwb_branch_unit #(.NUM_SLOTS(NS), .PC_W(PW), .RESET_VEC(RV)) u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .cur_pc(cur_pc),
        .slot_valid(slot_valid), .set_masks(set_masks), .clr_masks(clr_masks),
        .targets(targets), .cc_wr_en(cc_wr_en), .cc_wr_data(cc_wr_data),
        .next_pc(next_pc), .taken(taken), .win_slot(win_slot),
        .delay_slot(delay_slot), .cc_value(cc_value)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mix(input int unsigned a);
        logic [31:0] x;
        x = a * 32'h9E3779B1;
        return x ^ (x >> 13);
    endfunction

    function automatic logic met(input logic [7:0] f, input logic [7:0] ms, input logic [7:0] mc);
        return ((f & ms) == ms) && ((f & mc) == 8'h00);
    endfunction

    task automatic set_slot(input int s, input logic v, input logic [7:0] ms, input logic [7:0] mc, input logic [PW-1:0] t);
        slot_valid[s]       = v;
        set_masks[s*8 +: 8] = ms;
        clr_masks[s*8 +: 8] = mc;
        targets[s*PW +: PW] = t;
    endtask

    task automatic clear_slots();
        for (int s = 0; s < NS; s++) set_slot(s, 1'b0, 8'h00, 8'h00, '0);
    endtask

    task automatic write_cc(input logic [7:0] en, input logic [7:0] d);
        instr_valid = 1'b0;
        cc_wr_en = en; cc_wr_data = d;
        @(posedge clk); @(negedge clk);
        cc_wr_en = '0;
    endtask

    task automatic issue(input logic [PW-1:0] pc);
        cur_pc = pc; instr_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic et, input logic [1:0] ew, input logic [PW-1:0] epc);
        chk(taken == et, req, 32'(taken), 32'(et));
        if (et) chk(win_slot == ew, req, 32'(win_slot), 32'(ew));
        chk(next_pc == epc, req, 32'(next_pc), 32'(epc));
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(cc_value == 8'h00, "R1", 32'(cc_value), 0);
        chk(next_pc == RV, "R1", 32'(next_pc), 32'(RV));
        chk(taken == 1'b0 && delay_slot == 1'b0 && win_slot == 2'd0, "R1",
            {taken, delay_slot, win_slot}, 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);

        // R2 / R5 / R7: near-exhaustive sweep over flags and mask patterns
        for (int f = 0; f < 256; f++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] fl;
                logic [PW-1:0] pc;
                logic et;
                logic [1:0] ew;
                logic [PW-1:0] epc;
                fl = 8'(f);
                write_cc(8'hFF, fl);
                chk(cc_value == fl, "R11", 32'(cc_value), 32'(fl));
                pc = PW'(mix(f * 4 + k));
                et = 1'b0; ew = 2'd0; epc = pc + 1'b1;
                for (int s = NS - 1; s >= 0; s--) begin
                    logic [31:0] h;
                    logic [7:0] ms, mc;
                    logic v;
                    h  = mix(f * 16 + k * 4 + s + 7);
                    ms = h[7:0]  & (k[0] ? fl : 8'hFF);
                    mc = h[15:8] & (k[1] ? ~fl : 8'hFF);
                    v  = h[16] | h[17];
                    set_slot(s, v, ms, mc, PW'(h[31:16]));
                    if (v && met(fl, ms, mc)) begin
                        et = 1'b1; ew = 2'(s); epc = PW'(h[31:16]);
                    end
                end
                issue(pc);
                expect_res("R2 R5 R7 sweep", et, ew, epc);
            end
        end

        // R3: all-zero masks always taken, for any flags
        clear_slots();
        write_cc(8'hFF, 8'h5A);
        set_slot(2, 1'b1, 8'h00, 8'h00, 16'hBEEF);
        issue(16'h0010);
        expect_res("R3", 1'b1, 2'd2, 16'hBEEF);

        // R4: overlap never taken, lower-priority slot still resolves
        clear_slots();
        write_cc(8'hFF, 8'hFF);
        set_slot(0, 1'b1, 8'h04, 8'h04, 16'h1111);
        set_slot(1, 1'b1, 8'h00, 8'h00, 16'h2222);
        issue(16'h0020);
        expect_res("R4", 1'b1, 2'd1, 16'h2222);
        clear_slots();
        set_slot(0, 1'b1, 8'h81, 8'h01, 16'h1111);
        issue(16'h0030);
        expect_res("R4 alone", 1'b0, 2'd0, 16'h0031);

        // R5: all slots taken -> slot 0; slots 1 and 3 taken -> slot 1
        clear_slots();
        for (int s = 0; s < NS; s++) set_slot(s, 1'b1, 8'h00, 8'h00, PW'(16'hA000 + s));
        issue(16'h0040);
        expect_res("R5 all", 1'b1, 2'd0, 16'hA000);
        set_slot(0, 1'b0, 8'h00, 8'h00, 16'hA000);
        set_slot(2, 1'b1, 8'h00, 8'hFF, 16'hA002);
        issue(16'h0050);
        expect_res("R5 mid", 1'b1, 2'd1, 16'hA001);

        // R6: same-cycle write invisible to the instruction beside it
        clear_slots();
        write_cc(8'hFF, 8'h00);
        set_slot(0, 1'b1, 8'h01, 8'h00, 16'h7777);
        cc_wr_en = 8'hFF; cc_wr_data = 8'hFF;
        issue(16'h0060);
        cc_wr_en = 8'h00;
        expect_res("R6 old flags", 1'b0, 2'd0, 16'h0061);
        chk(cc_value == 8'hFF, "R6", 32'(cc_value), 32'hFF);
        issue(16'h0070);
        expect_res("R6 new flags", 1'b1, 2'd0, 16'h7777);

        // R7: wrap-around
        clear_slots();
        issue(16'hFFFF);
        expect_res("R7 wrap", 1'b0, 2'd0, 16'h0000);

        // R8: idle edge holds outputs
        set_slot(3, 1'b1, 8'h00, 8'h00, 16'h3333);
        issue(16'h0080);
        @(posedge clk); @(negedge clk);
        expect_res("R8 hold", 1'b1, 2'd3, 16'h3333);

        // R9: delay slot on not-taken branch, none for empty instr or idle
        clear_slots();
        set_slot(1, 1'b1, 8'h00, 8'hFF, 16'h4444);
        issue(16'h0090);
        chk(delay_slot == 1'b1, "R9 not-taken", 32'(delay_slot), 1);
        @(posedge clk); @(negedge clk);
        chk(delay_slot == 1'b0, "R9 idle", 32'(delay_slot), 0);
        clear_slots();
        issue(16'h00A0);
        chk(delay_slot == 1'b0, "R9 no slots", 32'(delay_slot), 0);

        // R10: invalid slot with always-true masks is ignored
        clear_slots();
        set_slot(0, 1'b0, 8'h00, 8'h00, 16'h5555);
        issue(16'h00B0);
        expect_res("R10", 1'b0, 2'd0, 16'h00B1);

        // R11: per-bit write enable
        write_cc(8'hFF, 8'h00);
        write_cc(8'h08, 8'hFF);
        chk(cc_value == 8'h08, "R11", 32'(cc_value), 32'h08);

        // R1: reset again clears state
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(cc_value == 8'h00 && next_pc == RV && !taken, "R1 re-reset",
            {cc_value, next_pc, 7'd0, taken}, {8'h00, RV, 8'h00});
        rst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule